// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block performs the data-processing operation of a 32-bit processor: sixteen logical, arithmetic, reverse-arithmetic, move and compare/test operations. It receives a 4-bit opcode, a first operand, a second operand that the barrel shifter outside the block has already shifted, the shifter's carry-out, the current N/Z/C/V flags and a set-flags bit. One clock later it presents the result, a write-enable for the destination register and the next flag values.

The block can also replace the first operand with the program-counter view the pipeline expects. When the first operand names the program counter, the block uses the instruction address plus 8. If the second operand is shifted by a register amount, it uses the instruction address plus 12. The register file, the shifter, mode changes and the pipeline flush after a program-counter write all stay outside the block.

A single adder serves every arithmetic opcode. The operands are swapped and inverted ahead of the adder, and the carry-in is chosen to match the opcode. A separate unit computes the bitwise operations. A flag unit combines the two sets of results.

Top module: `alu_dp`

## Requirements
- R1: While reset is held, and after it, `out_valid`, `wr_en`, `result` and `flags_out` are zero until an operation completes. An operation presented with `in_valid` high appears with `out_valid` high exactly one clock later. No cycle without `in_valid` produces `out_valid`.
- R2: The opcode encoding is AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. AND, EOR and ORR give the bitwise result. MOV gives operand 2. BIC gives op1 AND NOT op2. MVN gives NOT op2.
- R3: ADD gives op1+op2, SUB gives op1-op2 and RSB gives op2-op1, all modulo 2^32.
- R4: ADC gives op1+op2+C. SBC gives op1-op2-(1-C). RSC gives op2-op1-(1-C). C is bit 1 of `flags_in`.
- R5: TST, TEQ, CMP and CMN compute AND, XOR, subtract and add. `result` carries that value, `wr_en` stays low, and the flags update as for AND, EOR, SUB and ADD.
- R6: For a logical opcode (0, 1, 8, 9, 12 to 15) with set-flags high, the flags change as follows. N is the result's bit 31. Z is set when the result is zero. C takes `shift_carry`. V keeps its input value.
- R7: For an arithmetic opcode with set-flags high, C is the adder carry-out; for subtraction this means no borrow occurred. V marks signed overflow. N and Z follow the result.
- R8: With set-flags low, `flags_out` equals `flags_in` for every opcode. Non-compare opcodes still assert `wr_en`. The flags bus is {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R9: With `a_is_pc` high, operand 1 is `ins_addr`+8. If `b_reg_shift` is also high, operand 1 is `ins_addr`+12. With `a_is_pc` low, `op_a` is used unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand from the register file |
| op_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current {N,Z,C,V} |
| set_flags | input | 1 | Update the flags |
| a_is_pc | input | 1 | First operand is the program counter |
| b_reg_shift | input | 1 | Operand 2 was shifted by a register amount |
| ins_addr | input | 32 | Address of the executing instruction |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Operation value |
| wr_en | output | 1 | Write the destination register |
| flags_out | output | 4 | Next {N,Z,C,V} |

## Verification
The assertions assume that every input is held steady and known across the clock edge on which `in_valid` is sampled. They also assume that reset lasts at least one edge with `in_valid` low. The bench drives all inputs on the falling edge and holds `in_valid` low during reset, which satisfies both assumptions. The flag and write checks compare the outputs against inputs sampled one edge earlier, so the stimulus mixes back-to-back operations with idle cycles, and both states of set-flags, to exercise each property with different histories.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Compare/test group never writes a destination
  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  // Opcodes whose flags come from the bitwise unit
  function automatic logic op_is_logical(input logic [3:0] op);
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ,
      OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  // Operand swap for reverse forms
  function automatic logic op_swaps(input logic [3:0] op);
    return (op == OP_RSB) || (op == OP_RSC);
  endfunction

  // Second adder input is inverted for every subtract form
  function automatic logic op_inverts(input logic [3:0] op);
    case (op)
      OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

  // Carry-in: 1 for plain subtract, C for with-carry forms, 0 otherwise
  function automatic logic op_carry_in(input logic [3:0] op, input logic c_flag);
    case (op)
      OP_SUB, OP_RSB, OP_CMP:         return 1'b1;
      OP_ADC, OP_SBC, OP_RSC:         return c_flag;
      default:                        return 1'b0;
    endcase
  endfunction

  // Two's-complement overflow from the sign bits of the adder inputs and sum
  function automatic logic signed_ovf(input logic x_msb, input logic y_msb,
                                      input logic s_msb);
    return (x_msb == y_msb) && (s_msb != x_msb);
  endfunction

endpackage

// File: rtl/alu_opsel.sv
module alu_opsel #(
  parameter int W          = 32,
  parameter int PC_OFS_IMM = 8,
  parameter int PC_OFS_REG = 12
) (
  input  logic [W-1:0] a_raw,
  input  logic         a_is_pc,
  input  logic         b_reg_shift,
  input  logic [W-1:0] ins_addr,
  output logic [W-1:0] a_eff
);
  localparam logic [W-1:0] OFS_IMM = W'(PC_OFS_IMM);
  localparam logic [W-1:0] OFS_REG = W'(PC_OFS_REG);

  logic [W-1:0] pc_ofs;

  always_comb begin
    pc_ofs = b_reg_shift ? OFS_REG : OFS_IMM;
    a_eff  = a_is_pc ? (ins_addr + pc_ofs) : a_raw;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  import alu_pkg::*;

  always_comb begin
    case (alu_op_e'(op))
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_flag,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  import alu_pkg::*;

  logic [W-1:0] x_in;
  logic [W-1:0] y_pre;
  logic [W-1:0] y_in;
  logic         cin;
  logic [W:0]   wide;

  always_comb begin
    x_in  = op_swaps(op) ? b : a;
    y_pre = op_swaps(op) ? a : b;
    y_in  = op_inverts(op) ? ~y_pre : y_pre;
    cin   = op_carry_in(op, c_flag);
    wide  = {1'b0, x_in} + {1'b0, y_in} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = signed_ovf(x_in[W-1], y_in[W-1], wide[W-1]);
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic         set_flags,
  input  logic [W-1:0] res,
  input  logic         add_c,
  input  logic         add_v,
  input  logic         shift_carry,
  input  logic [3:0]   flags_in,
  output logic [3:0]   flags_nxt
);
  import alu_pkg::*;

  nzcv_t cur;
  nzcv_t upd;

  always_comb begin
    cur   = nzcv_t'(flags_in);
    upd.n = res[W-1];
    upd.z = (res == '0);
    if (op_is_logical(op)) begin
      upd.c = shift_carry;
      upd.v = cur.v;
    end else begin
      upd.c = add_c;
      upd.v = add_v;
    end
    flags_nxt = set_flags ? upd : cur;
  end
endmodule

// File: rtl/alu_dp.sv
module alu_dp #(
  parameter int W          = 32,
  parameter int PC_OFS_IMM = 8,
  parameter int PC_OFS_REG = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_carry,
  input  logic [3:0]   flags_in,
  input  logic         set_flags,
  input  logic         a_is_pc,
  input  logic         b_reg_shift,
  input  logic [W-1:0] ins_addr,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags_out
);
  import alu_pkg::*;

  // Named internal events, visible to the bound checker
  logic [W-1:0] a_eff;
  logic [W-1:0] logic_res;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;
  logic         is_logical;
  logic         is_compare;
  logic [W-1:0] res_nxt;
  logic [3:0]   flags_nxt;

  alu_opsel #(.W(W), .PC_OFS_IMM(PC_OFS_IMM), .PC_OFS_REG(PC_OFS_REG)) u_opsel (
    .a_raw      (op_a),
    .a_is_pc    (a_is_pc),
    .b_reg_shift(b_reg_shift),
    .ins_addr   (ins_addr),
    .a_eff      (a_eff)
  );

  alu_logic #(.W(W)) u_logic (
    .op (opcode),
    .a  (a_eff),
    .b  (op_b),
    .res(logic_res)
  );

  alu_adder #(.W(W)) u_adder (
    .op    (opcode),
    .a     (a_eff),
    .b     (op_b),
    .c_flag(flags_in[1]),
    .sum   (add_sum),
    .cout  (add_cout),
    .ovf   (add_ovf)
  );

  always_comb begin
    is_logical = op_is_logical(opcode);
    is_compare = op_is_compare(opcode);
    res_nxt    = is_logical ? logic_res : add_sum;
  end

  alu_flags #(.W(W)) u_flags (
    .op         (opcode),
    .set_flags  (set_flags),
    .res        (res_nxt),
    .add_c      (add_cout),
    .add_v      (add_ovf),
    .shift_carry(shift_carry),
    .flags_in   (flags_in),
    .flags_nxt  (flags_nxt)
  );

  // Output stage: one cycle of latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && !is_compare;
      if (in_valid) begin
        result    <= res_nxt;
        flags_out <= flags_nxt;
      end
    end
  end
endmodule

// File: rtl/alu_dp_chk.sv
module alu_dp_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [3:0]   opcode,
  input logic         shift_carry,
  input logic [3:0]   flags_in,
  input logic         set_flags,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   flags_out
);
  import alu_pkg::*;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                          // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                        // R1
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);                                             // R1
  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_compare(opcode)) |=> !wr_en);                  // R5
  AST_PLAIN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_is_compare(opcode)) |=> wr_en);                  // R8
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !set_flags) |=> (flags_out == $past(flags_in)));     // R8
  AST_LOGIC_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_flags && op_is_logical(opcode)) |=>
      (flags_out[1] == $past(shift_carry) && flags_out[0] == $past(flags_in[0]))); // R6
  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_flags) |=>
      (flags_out[3] == result[W-1] && flags_out[2] == (result == '0))); // R7
endmodule

bind alu_dp alu_dp_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .opcode     (opcode),
  .shift_carry(shift_carry),
  .flags_in   (flags_in),
  .set_flags  (set_flags),
  .out_valid  (out_valid),
  .result     (result),
  .wr_en      (wr_en),
  .flags_out  (flags_out)
);

// File: tb/alu_dp_test.sv
`timescale 1ns/1ps
module alu_dp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] op_a = '0, op_b = '0, ins_addr = '0;
  logic        shift_carry = 1'b0, set_flags = 1'b0, a_is_pc = 1'b0, b_reg_shift = 1'b0;
  logic [3:0]  flags_in = '0;
  logic        out_valid, wr_en;
  logic [31:0] result;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fl;
    int          cyc;
    int          req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  alu_dp uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry), .flags_in(flags_in),
    .set_flags(set_flags), .a_is_pc(a_is_pc), .b_reg_shift(b_reg_shift),
    .ins_addr(ins_addr), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .flags_out(flags_out)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit ovf64(input longint d);
    return (d > 64'sd2147483647) || (d < -64'sd2147483648);
  endfunction

  // Independent reference built from the requirements
  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a_in,
      input logic [31:0] b, input logic sc, input logic [3:0] fl, input logic sf,
      input logic apc, input logic brs, input logic [31:0] ia, input int req);
    exp_t e;
    logic [31:0] a, x, y, r;
    logic c, v, cin, logical, arith_sub;
    longint sx, sy, d;
    a = apc ? ia + (brs ? 32'd12 : 32'd8) : a_in;          // R9
    cin = fl[1];
    logical = 1'b0; c = 1'b0; v = 1'b0; arith_sub = 1'b0;
    x = a; y = b;
    if (op == 4'd3 || op == 4'd7) begin x = b; y = a; end
    sx = longint'($signed(x)); sy = longint'($signed(y));
    case (op)
      4'd0, 4'd8:  begin r = a & b; logical = 1; end
      4'd1, 4'd9:  begin r = a ^ b; logical = 1; end
      4'd12:       begin r = a | b; logical = 1; end
      4'd13:       begin r = b;     logical = 1; end
      4'd14:       begin r = a & ~b; logical = 1; end
      4'd15:       begin r = ~b;    logical = 1; end
      4'd4, 4'd11: begin r = x + y; c = ({32'd0, x} + {32'd0, y}) > 64'hFFFF_FFFF; d = sx + sy; v = ovf64(d); end
      4'd5:        begin r = x + y + {31'd0, cin};
                         c = ({32'd0, x} + {32'd0, y} + {63'd0, cin}) > 64'hFFFF_FFFF;
                         d = sx + sy + longint'(cin); v = ovf64(d); end
      4'd2, 4'd3, 4'd10: begin r = x - y; c = (x >= y); d = sx - sy; v = ovf64(d); end
      default:     begin r = x - y - {31'd0, ~cin};
                         c = ({32'd0, x} >= ({32'd0, y} + {63'd0, ~cin}));
                         d = sx - sy - longint'(~cin); v = ovf64(d); end
    endcase
    if (logical) begin c = sc; v = fl[0]; end
    e.res = r;
    e.wr  = !(op >= 4'd8 && op <= 4'd11);
    e.fl  = sf ? {r[31], r == 32'd0, c, v} : fl;
    e.cyc = 0;
    e.req = req;
    return e;
  endfunction

  task automatic drive(input int req, input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic sc, input logic [3:0] fl, input logic sf,
      input logic apc = 1'b0, input logic brs = 1'b0, input logic [31:0] ia = 32'd0);
    exp_t e;
    @(negedge clk);
    e = model(op, a, b, sc, fl, sf, apc, brs, ia, req);
    e.cyc = cyc;
    sb.push_back(e);
    in_valid = 1'b1; opcode = op; op_a = a; op_b = b; shift_carry = sc;
    flags_in = fl; set_flags = sf; a_is_pc = apc; b_reg_shift = brs; ins_addr = ia;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opcode = 4'hF; op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678; flags_in = 4'hF;
    end
  endtask

  // Monitor: compares each completed operation against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, 1, "out_valid with nothing issued", 64'(out_valid), 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.cyc + 1, 1, "latency", 64'(cyc - e.cyc), 64'd1);
          check(result == e.res, e.req, "result", 64'(result), 64'(e.res));
          check(wr_en == e.wr, e.req, "wr_en", 64'(wr_en), 64'(e.wr));
          check(flags_out == e.fl, e.req, "flags", 64'(flags_out), 64'(e.fl));
        end
      end else if (rst_n) begin
        check(wr_en == 1'b0, 1, "wr_en while idle", 64'(wr_en), 64'd0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, 1, "watchdog expired", 64'(sb.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, 1, "out_valid in reset", 64'(out_valid), 64'd0);
    check(wr_en == 1'b0, 1, "wr_en in reset", 64'(wr_en), 64'd0);
    check(result == 32'd0, 1, "result in reset", 64'(result), 64'd0);
    check(flags_out == 4'd0, 1, "flags in reset", 64'(flags_out), 64'd0);
    rst_n = 1'b1;
    idle(2);

    // R2: logical opcodes, flags untouched
    drive(2, 4'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 4'b1010, 1'b0);
    drive(2, 4'd1,  32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 4'b1010, 1'b0);
    drive(2, 4'd12, 32'h0000_00F0, 32'h0F00_0000, 1'b0, 4'b1010, 1'b0);
    drive(2, 4'd13, 32'h1111_1111, 32'hCAFE_F00D, 1'b0, 4'b1010, 1'b0);
    drive(2, 4'd14, 32'hFFFF_FFFF, 32'h0000_FF00, 1'b0, 4'b1010, 1'b0);
    drive(2, 4'd15, 32'h0,         32'h0F0F_0F0F, 1'b0, 4'b1010, 1'b0);
    idle(1);
    // R3: plain arithmetic with wrap
    drive(3, 4'd4, 32'hFFFF_FFFF, 32'd2, 1'b0, 4'b0000, 1'b0);
    drive(3, 4'd2, 32'd5, 32'd7, 1'b0, 4'b0000, 1'b0);
    drive(3, 4'd3, 32'd5, 32'd7, 1'b0, 4'b0000, 1'b0);
    // R4: carry forms with C clear and set
    drive(4, 4'd5, 32'd10, 32'd20, 1'b0, 4'b0010, 1'b0);
    drive(4, 4'd5, 32'd10, 32'd20, 1'b0, 4'b0000, 1'b0);
    drive(4, 4'd6, 32'd10, 32'd3, 1'b0, 4'b0000, 1'b0);
    drive(4, 4'd6, 32'd10, 32'd3, 1'b0, 4'b0010, 1'b0);
    drive(4, 4'd7, 32'd3, 32'd10, 1'b0, 4'b0000, 1'b1);
    drive(4, 4'd7, 32'd3, 32'd10, 1'b0, 4'b0010, 1'b1);
    idle(2);
    // R5: compare/test group, no writes
    drive(5, 4'd8,  32'hF0, 32'h0F, 1'b1, 4'b0001, 1'b1);
    drive(5, 4'd9,  32'h55, 32'h55, 1'b0, 4'b0000, 1'b1);
    drive(5, 4'd10, 32'd9,  32'd9,  1'b0, 4'b0000, 1'b1);
    drive(5, 4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b1);
    drive(5, 4'd10, 32'd4, 32'd9, 1'b0, 4'b0011, 1'b0);
    // R6: logical flags
    drive(6, 4'd0,  32'hFF00, 32'h00FF, 1'b1, 4'b0001, 1'b1);
    drive(6, 4'd15, 32'h0, 32'h0000_0001, 1'b0, 4'b0110, 1'b1);
    drive(6, 4'd13, 32'h0, 32'h8000_0000, 1'b1, 4'b0000, 1'b1);
    idle(1);
    // R7: arithmetic flags, overflow and borrow
    drive(7, 4'd4, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'b0000, 1'b1);
    drive(7, 4'd2, 32'h8000_0000, 32'd1, 1'b0, 4'b0000, 1'b1);
    drive(7, 4'd2, 32'd9, 32'd4, 1'b0, 4'b0000, 1'b1);
    drive(7, 4'd10, 32'd0, 32'd1, 1'b0, 4'b0010, 1'b1);
    drive(7, 4'd4, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000, 1'b1);
    drive(7, 4'd6, 32'd0, 32'd0, 1'b0, 4'b0000, 1'b1);
    // R8: set-flags low leaves flags alone but still writes
    drive(8, 4'd4, 32'h7FFF_FFFF, 32'd1, 1'b1, 4'b0101, 1'b0);
    drive(8, 4'd0, 32'h0, 32'h0, 1'b1, 4'b1000, 1'b0);
    idle(3);
    // R9: program-counter operand
    drive(9, 4'd4, 32'hFFFF_0000, 32'd0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 32'h0000_1000);
    drive(9, 4'd4, 32'hFFFF_0000, 32'd0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 32'h0000_1000);
    drive(9, 4'd4, 32'h0000_0040, 32'd4, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 32'h0000_1000);
    drive(9, 4'd2, 32'h0, 32'd8, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 32'h0000_0000);
    idle(3);

    // R1: every issued operation came back, nothing left over
    check(sb.size() == 0, 1, "scoreboard drained", 64'(sb.size()), 64'd0);
    check(out_valid == 1'b0, 1, "idle after drain", 64'(out_valid), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule